// File: doc/BRIEF.md
# Four-Phase Instruction Sequencer with Skip

This block steps a small 4-bit controller through its machine cycle and owns everything that decides which opcode byte runs next. Each machine cycle is four phases (T1, T3, T5, T7) carried by a one-hot ring that advances on the falling clock edge. At the close of T3 the fetched byte enters the instruction register, replaced by the no-op code 0x00 when the skip flag is set. At the close of T5 the skip flag is reloaded and the program counter advances. At the close of T7 jumps, calls and returns move the program counter.

The program counter is 13 bits: bank (bits 12:10), page (bits 9:6) and offset (bits 5:0). It lives in a four-level register stack; the level picked by a 2-bit stack pointer is the live counter, so a call only moves the pointer and a return only moves it back. Two prepare opcodes stage a page and a bank for the next jump or call. The program store, the data memory and the arithmetic unit sit outside. The external decoder supplies the evaluated skip condition for the instructions it owns, and a phase-multiplexed status pin reports four internal or external flags in turn.

Top module: `seq_sequencer`

## Requirements
- R1: The phase ring is one-hot and visits T1 (0001), T3 (0010), T5 (0100), T7 (1000) in that order, one step per falling clock edge, returning to T1 after T7.
- R2: At the falling edge ending T3, with run high, the instruction register loads the fetched byte, or 0x00 if the skip flag is set.
- R3: At the falling edge ending T5, with run high, the low 10 bits of the live counter (page and offset) increment modulo 1024 while the bank bits hold.
- R4: At the falling edge ending T5, an executed instruction that the sequencer does not own (anything other than call, jump, return, return-and-skip or prepare) loads the skip flag from skip_cond_i. A skipped instruction clears the flag.
- R5: A jump (0xC0 to 0xFF) loads the offset from opcode bits 5:0 at the end of T7. The page is the staged page if one is pending, or else the page of the already-incremented counter. The bank is the staged bank if one is pending, or else the current bank.
- R6: A call (0x80 to 0xBF) leaves the incremented return address in the current level and advances the stack pointer at the end of T5. At the end of T7 the new level gets offset = opcode bits 5:0, page = staged page or 15, and bank = staged bank or the caller's bank.
- R7: Return (0x01) decrements the stack pointer at the end of T7, so execution resumes at the stored return address. Three nested calls unwind in reverse order.
- R8: Prepare-page (0x60 to 0x6F) stages opcode bits 3:0 as the page. Prepare-bank (0x70 to 0x77) stages opcode bits 2:0 as the bank. Both stages clear when a jump or call consumes them.
- R9: Return-and-skip (0x02) pops like a return and sets the skip flag, so the instruction fetched at the return address becomes 0x00.
- R10: A skipped prepare opcode keeps the skip flag set, so the next instruction is skipped too. A skipped prepare stages nothing.
- R11: Load-immediate (0x40 to 0x4F) sets an internal flag, and any other fetched byte clears it. While the flag is set, a fetched load-immediate enters the instruction register as 0x00.
- R12: While run_i is low the ring keeps cycling, but the instruction register, counter, stack pointer and skip flag hold.
- R13: status_o shows dfloat_i in T1, bl_thirteen_i in T3, carry_i in T5 and the skip flag in T7.
- R14: Reset (rst_ni low) sets the phase to T1, and clears the counter, stack pointer, instruction register, skip flag and staged page and bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; state changes on the falling edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | High lets instruction state advance |
| rom_data_i | input | 8 | Opcode byte fetched at the live counter |
| skip_cond_i | input | 1 | Evaluated skip condition of the current instruction |
| dfloat_i | input | 1 | Data-bus-not-driven flag shown in T1 |
| bl_thirteen_i | input | 1 | Row-register-equals-13 flag shown in T3 |
| carry_i | input | 1 | Carry flag shown in T5 |
| rom_addr_o | output | 13 | Live program counter |
| ir_o | output | 8 | Instruction register |
| phase_o | output | 4 | One-hot phase (bit 0 = T1 ... bit 3 = T7) |
| status_o | output | 1 | Phase-multiplexed status flag |

## Verification
A corrupted stack pointer or stack level shows on rom_addr_o at the T1 after the faulty T7, because the live counter is the selected level itself. A stuck or misplaced skip flag shows in the T7 slot of status_o within the same machine cycle, and as a 0x00 or non-zero ir_o one cycle later. Staged page or bank errors stay hidden until the next jump or call, so the bench places transfers directly after each prepare and after each consumption.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int OP_W   = 8;
  localparam int OFS_W  = 6;
  localparam int PAGE_W = 4;
  localparam int BANK_W = 3;
  localparam int LOW_W  = OFS_W + PAGE_W;
  localparam int PC_W   = LOW_W + BANK_W;
  localparam int PHASES = 4;

  localparam int PH_T1 = 0;
  localparam int PH_T3 = 1;
  localparam int PH_T5 = 2;
  localparam int PH_T7 = 3;

  localparam logic [OP_W-1:0] OP_NOP = 8'h00;
  localparam logic [OP_W-1:0] OP_RET = 8'h01;
  localparam logic [OP_W-1:0] OP_RTS = 8'h02;

  function automatic logic op_is_call(input logic [OP_W-1:0] op);
    return op[7:6] == 2'b10;
  endfunction
  function automatic logic op_is_jump(input logic [OP_W-1:0] op);
    return op[7:6] == 2'b11;
  endfunction
  function automatic logic op_is_lai(input logic [OP_W-1:0] op);
    return op[7:4] == 4'h4;
  endfunction
  function automatic logic op_is_pg(input logic [OP_W-1:0] op);
    return op[7:4] == 4'h6;
  endfunction
  function automatic logic op_is_bk(input logic [OP_W-1:0] op);
    return op[7:3] == 5'b01110;
  endfunction
  function automatic logic op_is_own(input logic [OP_W-1:0] op);
    return op_is_call(op) || op_is_jump(op) || op_is_pg(op) || op_is_bk(op)
           || op == OP_RET || op == OP_RTS;
  endfunction
endpackage

// File: rtl/seq_phase_ring.sv
module seq_phase_ring
  import seq_pkg::*;
#(
  parameter int N = PHASES
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  output logic [N-1:0] phase_o
);
  logic [N-1:0] ring_q;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ring_q <= N'(1);
    else         ring_q <= {ring_q[N-2:0], ring_q[N-1]};
  end

  assign phase_o = ring_q;
endmodule

// File: rtl/seq_fetch.sv
module seq_fetch
  import seq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic            load_i,
  input  logic            cond_upd_i,
  input  logic [OP_W-1:0] op_i,
  input  logic            cond_i,
  output logic [OP_W-1:0] ir_o,
  output logic            skip_o,
  output logic            lai_o
);
  logic [OP_W-1:0] ir_q;
  logic            skip_q, lai_q, pass_q, skip_d;

  // skip source: prepare passes it through, own opcodes decide, others take cond_i
  always_comb begin
    if (pass_q)                skip_d = skip_q;
    else if (skip_q)           skip_d = 1'b0;
    else if (ir_q == OP_RTS)   skip_d = 1'b1;
    else if (op_is_own(ir_q))  skip_d = 1'b0;
    else                       skip_d = cond_i;
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ir_q   <= OP_NOP;
      skip_q <= 1'b0;
      lai_q  <= 1'b0;
      pass_q <= 1'b0;
    end else if (run_i) begin
      if (load_i) begin
        ir_q   <= (skip_q || (lai_q && op_is_lai(op_i))) ? OP_NOP : op_i;
        lai_q  <= op_is_lai(op_i);
        pass_q <= op_is_pg(op_i) || op_is_bk(op_i);
      end
      if (cond_upd_i) skip_q <= skip_d;
    end
  end

  assign ir_o   = ir_q;
  assign skip_o = skip_q;
  assign lai_o  = lai_q;
endmodule

// File: rtl/seq_pc_stack.sv
module seq_pc_stack
  import seq_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int SP_W = $clog2(DEPTH)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic            inc_i,
  input  logic            xfer_i,
  input  logic [OP_W-1:0] ir_i,
  output logic [PC_W-1:0] pc_o,
  output logic [SP_W-1:0] sp_o
);
  localparam logic [SP_W-1:0]   SP_ONE   = SP_W'(1);
  localparam logic [PAGE_W-1:0] PG_CALL  = '1;

  logic [PC_W-1:0]   lvl_q [DEPTH];
  logic [SP_W-1:0]   sp_q, sp_dec;
  logic [PAGE_W-1:0] pg_q;
  logic [BANK_W-1:0] bk_q;
  logic              pg_v_q, bk_v_q;

  logic [PC_W-1:0]   pc, pc_inc, jmp_tgt, call_tgt;
  logic [BANK_W-1:0] caller_bank;
  logic              is_call, is_jump, is_pop;

  assign sp_dec      = sp_q - SP_ONE;
  assign pc          = lvl_q[sp_q];
  assign caller_bank = lvl_q[sp_dec][PC_W-1:LOW_W];
  assign pc_inc      = {pc[PC_W-1:LOW_W], pc[LOW_W-1:0] + LOW_W'(1)};

  assign is_call = op_is_call(ir_i);
  assign is_jump = op_is_jump(ir_i);
  assign is_pop  = (ir_i == OP_RET) || (ir_i == OP_RTS);

  assign jmp_tgt  = {bk_v_q ? bk_q : pc[PC_W-1:LOW_W],
                     pg_v_q ? pg_q : pc[LOW_W-1:OFS_W],
                     ir_i[OFS_W-1:0]};
  assign call_tgt = {bk_v_q ? bk_q : caller_bank,
                     pg_v_q ? pg_q : PG_CALL,
                     ir_i[OFS_W-1:0]};

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) lvl_q[i] <= '0;
      sp_q <= '0;
    end else if (run_i) begin
      if (inc_i) begin
        lvl_q[sp_q] <= pc_inc;
        if (is_call) sp_q <= sp_q + SP_ONE;
      end
      if (xfer_i) begin
        if (is_jump)      lvl_q[sp_q] <= jmp_tgt;
        else if (is_call) lvl_q[sp_q] <= call_tgt;
        if (is_pop) sp_q <= sp_dec;
      end
    end
  end

  // staged page/bank, consumed by jump or call
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pg_q   <= '0;
      bk_q   <= '0;
      pg_v_q <= 1'b0;
      bk_v_q <= 1'b0;
    end else if (run_i && xfer_i) begin
      if (is_jump || is_call) begin
        pg_v_q <= 1'b0;
        bk_v_q <= 1'b0;
      end else if (op_is_pg(ir_i)) begin
        pg_q   <= ir_i[PAGE_W-1:0];
        pg_v_q <= 1'b1;
      end else if (op_is_bk(ir_i)) begin
        bk_q   <= ir_i[BANK_W-1:0];
        bk_v_q <= 1'b1;
      end
    end
  end

  assign pc_o = pc;
  assign sp_o = sp_q;
endmodule

// File: rtl/seq_sequencer.sv
module seq_sequencer
  import seq_pkg::*;
#(
  parameter int STACK_DEPTH = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic [OP_W-1:0] rom_data_i,
  input  logic            skip_cond_i,
  input  logic            dfloat_i,
  input  logic            bl_thirteen_i,
  input  logic            carry_i,
  output logic [PC_W-1:0] rom_addr_o,
  output logic [OP_W-1:0] ir_o,
  output logic [PHASES-1:0] phase_o,
  output logic            status_o
);
  localparam int SP_W = $clog2(STACK_DEPTH);

  logic [PHASES-1:0] phase_w;
  logic [OP_W-1:0]   ir_w;
  logic              skip_w, lai_w;
  logic [SP_W-1:0]   sp_w;

  seq_phase_ring #(.N(PHASES)) u_ring (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .phase_o (phase_w)
  );

  seq_fetch u_fetch (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run_i),
    .load_i     (phase_w[PH_T3]),
    .cond_upd_i (phase_w[PH_T5]),
    .op_i       (rom_data_i),
    .cond_i     (skip_cond_i),
    .ir_o       (ir_w),
    .skip_o     (skip_w),
    .lai_o      (lai_w)
  );

  seq_pc_stack #(.DEPTH(STACK_DEPTH)) u_pc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_i),
    .inc_i  (phase_w[PH_T5]),
    .xfer_i (phase_w[PH_T7]),
    .ir_i   (ir_w),
    .pc_o   (rom_addr_o),
    .sp_o   (sp_w)
  );

  assign status_o = (phase_w[PH_T1] & dfloat_i)
                  | (phase_w[PH_T3] & bl_thirteen_i)
                  | (phase_w[PH_T5] & carry_i)
                  | (phase_w[PH_T7] & skip_w);

  assign ir_o    = ir_w;
  assign phase_o = phase_w;
endmodule

// File: rtl/seq_sequencer_chk.sv
module seq_sequencer_chk
  import seq_pkg::*;
#(
  parameter int SP_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              run_i,
  input logic [PHASES-1:0] phase_i,
  input logic [OP_W-1:0]   ir_i,
  input logic [OP_W-1:0]   rom_data_i,
  input logic [PC_W-1:0]   addr_i,
  input logic              skip_i,
  input logic              lai_i,
  input logic [SP_W-1:0]   sp_i
);
  AST_RING_ONEHOT: assert property (@(negedge clk_i) disable iff (!rst_ni)
    $countones(phase_i) == 1); // R1
  AST_RING_WRAP: assert property (@(negedge clk_i) disable iff (!rst_ni)
    phase_i[PH_T7] |=> phase_i[PH_T1]); // R1
  AST_SKIP_NOP: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (phase_i[PH_T3] && run_i && skip_i) |=> ir_i == OP_NOP); // R2
  AST_CALL_PUSH: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (phase_i[PH_T5] && run_i && op_is_call(ir_i)) |=> sp_i == $past(sp_i) + SP_W'(1)); // R6
  AST_LAI_SUPPRESS: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (phase_i[PH_T3] && run_i && lai_i && op_is_lai(rom_data_i)) |=> ir_i == OP_NOP); // R11
  AST_HOLD_PC: assert property (@(negedge clk_i) disable iff (!rst_ni)
    !$past(run_i) |-> $stable(addr_i)); // R12
  AST_HOLD_IR: assert property (@(negedge clk_i) disable iff (!rst_ni)
    !$past(run_i) |-> ($stable(ir_i) && $stable(skip_i))); // R12
endmodule

bind seq_sequencer seq_sequencer_chk #(.SP_W(SP_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .run_i      (run_i),
  .phase_i    (phase_o),
  .ir_i       (ir_o),
  .rom_data_i (rom_data_i),
  .addr_i     (rom_addr_o),
  .skip_i     (skip_w),
  .lai_i      (lai_w),
  .sp_i       (sp_w)
);

// File: tb/seq_sequencer_test.sv
module seq_sequencer_test;
  logic        clk = 1'b0;
  logic        rst_ni, run_i, skip_cond_i, dfloat_i, bl_thirteen_i, carry_i;
  logic [7:0]  rom_data_i, ir_o;
  logic [12:0] rom_addr_o;
  logic [3:0]  phase_o;
  logic        status_o;
  logic        s1, s3, s5, s7;
  logic        exp_skip;
  int          n_cmp = 0, n_bad = 0;

  always #5 clk = ~clk;

  seq_sequencer uut (
    .clk_i(clk), .rst_ni(rst_ni), .run_i(run_i), .rom_data_i(rom_data_i),
    .skip_cond_i(skip_cond_i), .dfloat_i(dfloat_i), .bl_thirteen_i(bl_thirteen_i),
    .carry_i(carry_i), .rom_addr_o(rom_addr_o), .ir_o(ir_o), .phase_o(phase_o),
    .status_o(status_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one machine cycle; leaves the bench at the following T1
  task automatic mc(input logic [7:0] op, input logic cond, input logic run = 1'b1);
    while (phase_o !== 4'b0001) @(posedge clk);
    rom_data_i = op; skip_cond_i = cond; run_i = run;
    #1;
    chk("R1 phase T1", 32'(phase_o), 1); s1 = status_o;
    @(posedge clk); chk("R1 phase T3", 32'(phase_o), 2); s3 = status_o;
    @(posedge clk); chk("R1 phase T5", 32'(phase_o), 4); s5 = status_o;
    @(posedge clk); chk("R1 phase T7", 32'(phase_o), 8); s7 = status_o;
    @(posedge clk);
  endtask

  task automatic pc_is(input string req, input int exp);
    chk(req, 32'(rom_addr_o), exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; run_i = 1'b1; rom_data_i = 8'h00; skip_cond_i = 1'b0;
    dfloat_i = 1'b0; bl_thirteen_i = 1'b0; carry_i = 1'b0;
    repeat (3) @(posedge clk);
    chk("R14 reset pc", 32'(rom_addr_o), 0);
    chk("R14 reset ir", 32'(ir_o), 0);
    chk("R14 reset phase", 32'(phase_o), 1);
    rst_ni = 1'b1;

    mc(8'h00, 1'b0); pc_is("R3 increment", 1); chk("R14 skip clear", 32'(s7), 0);
    mc(8'h10, 1'b1); chk("R2 load", 32'(ir_o), 8'h10); chk("R4 cond sets skip", 32'(s7), 1); pc_is("R3", 2);
    mc(8'h11, 1'b1); chk("R2 skipped nop", 32'(ir_o), 0); chk("R4 skipped clears", 32'(s7), 0); pc_is("R3", 3);

    for (int t = 0; t < 64; t++) begin
      mc(8'hC0 | 8'(t), 1'b0);
      pc_is("R5 jump sweep", t);
    end
    mc(8'h00, 1'b0); pc_is("R3 page carry", 64);

    mc(8'h75, 1'b0); pc_is("R8 prepare bank", 65);
    mc(8'h6F, 1'b0); pc_is("R8 prepare page", 66);
    mc(8'hFF, 1'b0); pc_is("R5 staged jump", 6143);
    mc(8'h00, 1'b0); pc_is("R3 bank held", 5120);

    mc(8'hAA, 1'b0); pc_is("R6 call page 15", 6122);
    mc(8'h01, 1'b0); pc_is("R7 return", 5121);
    mc(8'h63, 1'b0); pc_is("R8", 5122);
    mc(8'h85, 1'b0); pc_is("R8 staged call", 5317);
    mc(8'h01, 1'b0); pc_is("R7 return", 5123);
    mc(8'hC7, 1'b0); pc_is("R8 stage cleared jump", 5127);
    mc(8'h80, 1'b0); pc_is("R8 stage cleared call", 6080);
    mc(8'h01, 1'b0); pc_is("R7", 5128);

    mc(8'h81, 1'b0); pc_is("R7 nest1", 6081);
    mc(8'h90, 1'b0); pc_is("R7 nest2", 6096);
    mc(8'hA0, 1'b0); pc_is("R7 nest3", 6112);
    mc(8'h01, 1'b0); pc_is("R7 unwind3", 6097);
    mc(8'h01, 1'b0); pc_is("R7 unwind2", 6082);
    mc(8'h01, 1'b0); pc_is("R7 unwind1", 5129);

    mc(8'h84, 1'b0); pc_is("R6", 6084);
    mc(8'h02, 1'b0); pc_is("R9 pop", 5130); chk("R9 skip set", 32'(s7), 1);
    mc(8'h10, 1'b0); chk("R9 next skipped", 32'(ir_o), 0); pc_is("R9", 5131);

    mc(8'h10, 1'b1); chk("R4", 32'(s7), 1); pc_is("R3", 5132);
    mc(8'h6A, 1'b0); chk("R10 pp skipped", 32'(ir_o), 0); chk("R10 skip kept", 32'(s7), 1); pc_is("R10", 5133);
    mc(8'hC3, 1'b0); chk("R10 jump skipped", 32'(ir_o), 0); pc_is("R10 no jump", 5134); chk("R10 skip ends", 32'(s7), 0);
    mc(8'h80, 1'b0); pc_is("R10 nothing staged", 6080);
    mc(8'h01, 1'b0); pc_is("R7", 5135);

    mc(8'h45, 1'b0); chk("R11 first lai", 32'(ir_o), 8'h45);
    mc(8'h47, 1'b0); chk("R11 second lai", 32'(ir_o), 0);
    mc(8'h49, 1'b0); chk("R11 third lai", 32'(ir_o), 0);
    mc(8'h00, 1'b0); chk("R11 break", 32'(ir_o), 0);
    mc(8'h4A, 1'b0); chk("R11 new run", 32'(ir_o), 8'h4A); pc_is("R11 pc", 5140);

    mc(8'h10, 1'b1); pc_is("R12 setup", 5141);
    mc(8'h20, 1'b0, 1'b0);
    chk("R12 ir held", 32'(ir_o), 8'h10); pc_is("R12 pc held", 5141); chk("R12 skip held", 32'(s7), 1);
    mc(8'h20, 1'b0); chk("R12 resume skipped", 32'(ir_o), 0); pc_is("R12 resume", 5142);

    exp_skip = 1'b0;
    for (int k = 0; k < 16; k++) begin
      dfloat_i = k[0]; bl_thirteen_i = k[1]; carry_i = k[2];
      mc(8'h00, k[3]);
      exp_skip = exp_skip ? 1'b0 : k[3];
      chk("R13 T1 dfloat", 32'(s1), 32'(k[0]));
      chk("R13 T3 bl13", 32'(s3), 32'(k[1]));
      chk("R13 T5 carry", 32'(s5), 32'(k[2]));
      chk("R13 T7 skip", 32'(s7), 32'(exp_skip));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule